// File: doc/BRIEF.md
# SMBus Packet Error Code Unit

This block keeps the running CRC-8 of an SMBus message as its bytes go past, one byte per strobe, and uses it both ways. A transmitter reads the current code from `pec_code` and sends it as the last byte of the message. A receiver marks the final byte it gets as the PEC byte. The block then compares that byte with the code it has built up and raises a one-cycle NACK request when the two differ.

The byte engine outside the block decides which bytes belong to a message, which byte opens a new message (the first byte after a stop), and which byte is the PEC byte. The block does no bus timing and no byte counting. Address bytes, including the one sent after a repeated start, are folded in like any other byte. A whole byte is folded in within a single clock cycle.

Top module: `smbus_pec_unit`

## Requirements
- R1: After reset, `pec_code` is 0x00 and `pec_match`, `pec_err` and `nack_req` are all 0.
- R2: The code is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, MSB first, no reflection and no final XOR. The updated code appears on `pec_code` in the cycle after the strobe. The ASCII bytes "123456789" give 0xF4.
- R3: Every non-PEC byte strobed without `msg_start` is folded into the running code. This includes an address byte sent after a repeated start.
- R4: A strobe with `msg_start`=1 restarts the code from 0x00 and folds that same byte in.
- R5: While `byte_vld` is 0, `pec_code` and both result flags keep their values, whatever is on the other inputs.
- R6: A byte strobed with `pec_mark`=1 is not folded in, so `pec_code` is unchanged after it.
- R7: A PEC byte that equals the code sets `pec_match`=1 and `pec_err`=0, and no NACK request follows.
- R8: A PEC byte that differs from the code sets `pec_err`=1 and `pec_match`=0, starting in the cycle after the strobe. When `rx_mode`=1, `nack_req` is high for exactly that one cycle.
- R9: When `rx_mode`=0, a mismatched PEC byte still sets `pec_err`, but `nack_req` stays 0.
- R10: The result flags hold until the next strobe. A strobe of a byte that is not a PEC byte clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | One message byte is present this cycle |
| byte_data | input | 8 | Message byte (address bytes include the R/W bit) |
| msg_start | input | 1 | The byte opens a new message; the code restarts |
| pec_mark | input | 1 | The byte is the PEC byte of the message |
| rx_mode | input | 1 | 1 when receiving; enables the NACK request |
| pec_code | output | 8 | Running code; the byte to append when transmitting |
| pec_match | output | 1 | The last PEC byte equalled the code |
| pec_err | output | 1 | The last PEC byte differed from the code |
| nack_req | output | 1 | One-cycle request to NACK a mismatched received PEC byte |

## Verification
A wrong CRC state cannot be hidden. `pec_code` exposes the register one cycle after each strobe, so a bad fold, a missed restart, or a restart on a repeated start shows on the very next byte. The bench compares `pec_code` after every byte with a bit-serial model of its own. A fault in the compare path, or in the mode gating, shows on the flags and on `nack_req` in the cycle after the PEC strobe. It shows again one idle cycle later, where the flags must still hold and the pulse must already be gone.

// File: rtl/pec_pkg.sv
package pec_pkg;

  localparam int unsigned PEC_W = 8;

  typedef logic [PEC_W-1:0] pec_t;

  // Folds one whole byte into the code, MSB first, in a single step.
  function automatic pec_t pec_fold(pec_t crc, pec_t din, pec_t poly);
    pec_t acc;
    acc = crc ^ din;
    for (int k = 0; k < PEC_W; k++) begin
      if (acc[PEC_W-1]) acc = (acc << 1) ^ poly;
      else              acc = acc << 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/pec_crc_core.sv
module pec_crc_core
  import pec_pkg::*;
#(
  parameter pec_t POLY = 8'h07,
  parameter pec_t INIT = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic restart,
  input  logic hold,
  input  pec_t din,
  output pec_t crc_q,
  output pec_t crc_base
);

  pec_t crc_nxt;

  // The code a PEC byte is compared against: INIT if this byte opens a message.
  always_comb begin
    crc_base = restart ? INIT : crc_q;
    crc_nxt  = hold ? crc_base : pec_fold(crc_base, din, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= INIT;
    else if (stb) crc_q <= crc_nxt;
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(crc_q));

  // R6
  pec_not_folded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && hold && !restart) |=> $stable(crc_q));

  // R4
  restart_pec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && hold && restart) |=> (crc_q == INIT));

endmodule

// File: rtl/pec_check.sv
module pec_check
  import pec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic is_pec,
  input  logic rx_mode,
  input  pec_t rx_byte,
  input  pec_t code,
  output logic match_q,
  output logic err_q,
  output logic nack_q
);

  logic cmp_neq;
  logic pec_seen;

  assign cmp_neq  = (rx_byte != code);
  assign pec_seen = stb && is_pec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      err_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      nack_q <= pec_seen && rx_mode && cmp_neq;
      if (stb) begin
        match_q <= is_pec && !cmp_neq;
        err_q   <= is_pec && cmp_neq;
      end
    end
  end

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_q && err_q));

  // R8
  nack_with_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_q |-> err_q);

  // R8
  nack_follows_pec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_q |-> $past(pec_seen));

  // R10
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !is_pec) |=> (!match_q && !err_q));

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(match_q) && $stable(err_q)));

endmodule

// File: rtl/smbus_pec_unit.sv
module smbus_pec_unit
  import pec_pkg::*;
#(
  parameter logic [7:0] POLY = 8'h07,
  parameter logic [7:0] INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       msg_start,
  input  logic       pec_mark,
  input  logic       rx_mode,
  output logic [7:0] pec_code,
  output logic       pec_match,
  output logic       pec_err,
  output logic       nack_req
);

  pec_t crc_q;
  pec_t crc_base;

  pec_crc_core #(.POLY(POLY), .INIT(INIT)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (byte_vld),
    .restart  (msg_start),
    .hold     (pec_mark),
    .din      (byte_data),
    .crc_q    (crc_q),
    .crc_base (crc_base)
  );

  pec_check u_check (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (byte_vld),
    .is_pec  (pec_mark),
    .rx_mode (rx_mode),
    .rx_byte (byte_data),
    .code    (crc_base),
    .match_q (pec_match),
    .err_q   (pec_err),
    .nack_q  (nack_req)
  );

  assign pec_code = crc_q;

  // R9
  nack_rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nack_req |-> $past(rx_mode && byte_vld && pec_mark));

endmodule

// File: tb/tb_smbus_pec_unit.sv
module tb_smbus_pec_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       msg_start = 1'b0;
  logic       pec_mark = 1'b0;
  logic       rx_mode = 1'b0;
  logic [7:0] pec_code;
  logic       pec_match, pec_err, nack_req;

  int total = 0;
  int bad = 0;
  logic [7:0] model = 8'h00;

  always #4 clk = ~clk;

  smbus_pec_unit dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
    .msg_start(msg_start), .pec_mark(pec_mark), .rx_mode(rx_mode),
    .pec_code(pec_code), .pec_match(pec_match), .pec_err(pec_err),
    .nack_req(nack_req)
  );

  typedef struct packed {
    logic       st;
    logic       pec;
    logic       rx;
    logic [7:0] corrupt;
    logic [7:0] data;
    logic       em;
    logic       ee;
    logic       en;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hA6, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h10, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'hA7, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h55, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h31, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h32, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h34, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h35, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h36, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h37, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h38, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h39, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h5A, 8'h00, 1'b0, 1'b1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'hB0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0}
  };

  // Bit-serial restatement of the code: one data bit per shift.
  function automatic logic [7:0] ref_step(logic [7:0] c, logic [7:0] d);
    logic fb;
    for (int b = 7; b >= 0; b--) begin
      fb = c[7] ^ d[b];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    byte_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model = 8'h00;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 code", pec_code, 8'h00);
    check("R1 flags", {5'd0, pec_match, pec_err, nack_req}, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] d;
      @(negedge clk);
      if (TBL[i].st) model = 8'h00;
      d = TBL[i].pec ? (model ^ TBL[i].corrupt) : TBL[i].data;
      if (!TBL[i].pec) model = ref_step(model, d);
      byte_vld  = 1'b1;
      byte_data = d;
      msg_start = TBL[i].st;
      pec_mark  = TBL[i].pec;
      rx_mode   = TBL[i].rx;
      @(negedge clk);
      byte_vld = 1'b0;
      // R2 R3 R4 R6: running code after every byte
      check("R2/R3/R4/R6 code", pec_code, model);
      // R7 R8 R9 R10: flags and NACK pulse
      check("R7/R10 match", {7'd0, pec_match}, {7'd0, TBL[i].em});
      check("R8/R9 err", {7'd0, pec_err}, {7'd0, TBL[i].ee});
      check("R8/R9 nack", {7'd0, nack_req}, {7'd0, TBL[i].en});
      if (i == 13) check("R2 check value", pec_code, 8'hF4);
      @(negedge clk);
      // R8 single-cycle pulse; R10 flags held while idle
      check("R8 nack width", {7'd0, nack_req}, 8'h00);
      check("R10 hold", {6'd0, pec_match, pec_err}, {6'd0, TBL[i].em, TBL[i].ee});
    end

    // R5: garbage on the inputs with byte_vld low changes nothing
    held = pec_code;
    @(negedge clk);
    byte_data = 8'h3C; msg_start = 1'b1; pec_mark = 1'b1; rx_mode = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 code stable", pec_code, held);
    check("R5 flags stable", {6'd0, pec_match, pec_err}, 8'h02);
    check("R5 no nack", {7'd0, nack_req}, 8'h00);

    // R1 again after a mid-run reset
    do_reset();
    check("R1 code after reset", pec_code, 8'h00);
    check("R1 flags after reset", {5'd0, pec_match, pec_err, nack_req}, 8'h00);

    // R4: start byte 0x00 on a nonzero code gives 0x00; then 0x07 from 0x01
    @(negedge clk);
    byte_vld = 1'b1; byte_data = 8'h01; msg_start = 1'b1; pec_mark = 1'b0;
    @(negedge clk);
    byte_data = 8'h00; msg_start = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
    check("R4 restart", pec_code, 8'h00);
    @(negedge clk);
    byte_vld = 1'b1; byte_data = 8'h01; msg_start = 1'b0;
    @(negedge clk);
    byte_vld = 1'b0;
    check("R2 single byte", pec_code, 8'h07);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule